// File: doc/BRIEF.md
# Reliable-Transfer Control Frame Parser

This block watches the receive side of an Ethernet link and picks out the small control frames of a lightweight reliable-transfer protocol. Bytes arrive one per qualified cycle, with a marker on the first byte and a marker on the last byte of each frame. The parser keeps only the few header fields it needs. These are a running match of the destination address against the configured station address, the source address, the frame type word and the 16-bit command word. Bytes past the fixed header, including padding up to the minimum frame size, never reach any state.

The frame must be addressed to this station and must carry the type word 0xFADE. If so, the command word selects one of three events. Each event is reported as a one-cycle pulse. Start also records the sender's address, so that the transmit side knows where to send data. Acknowledge also reports the 16-bit sequence word that follows the command, split into a set number and a packet slot. Stop asks for an immediate halt. Frames that belong to someone else, carry another type or command, or end too early leave every output untouched.

Top module: `ctrl_frame_parser`

## Requirements
- R1: While reset is asserted and right after it, all three pulses are low and peer_mac, ack_set and ack_slot are zero.
- R2: A frame starts with rx_sof and runs up to rx_eof. Byte positions count from 0 at rx_sof. Positions 0-5 hold the destination address, 6-11 the source address, 12-13 the type word and 14-15 the command word, each sent most significant byte first. If the frame is ours and its command is 0x0001, start_pulse is high for exactly the one cycle after byte 15 is taken.
- R3: Command 0x0005 gives a single stop_pulse in the cycle after byte 15 is taken.
- R4: Command 0x0003 gives a single ack_pulse in the cycle after byte 17 is taken. The sequence word is byte 16 followed by byte 17. In the same cycle, ack_slot shows its low SLOT_W bits and ack_set shows its upper bits. Both hold their values until the next acknowledge.
- R5: A start frame loads peer_mac with the source address from bytes 6-11, with byte 6 as the most significant byte. No other frame changes peer_mac.
- R6: A frame whose destination address differs from local_mac in any byte gives no pulse.
- R7: A frame whose type word is not 0xFADE gives no pulse.
- R8: A command word other than 0x0001, 0x0003 and 0x0005 gives no pulse.
- R9: A frame whose rx_eof comes before byte 15 gives no pulse. An acknowledge frame whose rx_eof comes before byte 17 gives no pulse.
- R10: Bytes after position 17, such as padding up to 64 bytes, have no effect, even when they look like header or command bytes.
- R11: A byte is taken only when rx_valid is high. Idle cycles inside a frame do not disturb parsing. Bytes outside a frame (valid with no open frame and no rx_sof) are ignored. An rx_sof in the middle of a frame restarts parsing at position 0.
- R12: At most one of start_pulse, stop_pulse and ack_pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| local_mac | input | 48 | Station address that frames must be sent to |
| rx_valid | input | 1 | rx_byte carries a byte this cycle |
| rx_byte | input | 8 | Received byte |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| start_pulse | output | 1 | Start command received |
| stop_pulse | output | 1 | Stop command received |
| ack_pulse | output | 1 | Acknowledge received; ack_set and ack_slot are updated |
| ack_set | output | 16-SLOT_W | Set number from the last acknowledge |
| ack_slot | output | SLOT_W | Packet slot from the last acknowledge |
| peer_mac | output | 48 | Source address of the last start frame |

## Verification
The main decode is driven with full 64-byte frames and minimum-length frames. Each command is sent with its correct header and again with one field disturbed: the low or the high byte of the destination address, the type word, or either byte of the command. This shows which field each rejection depends on. Frames are cut off one byte before and exactly at the deciding byte, which separates a decision taken on byte 15 or 17 from one taken at end of frame. Idle gaps, bytes with no open frame and restarts in the middle of a frame test the stream framing. Padding that mimics a start command shows whether positions past the header are really ignored.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  localparam int unsigned OCTET_W = 8;
  localparam int unsigned MAC_W   = 48;
  localparam int unsigned SEQ_W   = 16;

  localparam logic [15:0] FRAME_TYPE = 16'hFADE;
  localparam logic [15:0] CMD_WORD_START = 16'h0001;
  localparam logic [15:0] CMD_WORD_ACK   = 16'h0003;
  localparam logic [15:0] CMD_WORD_STOP  = 16'h0005;

  // header layout, byte offsets from the first byte of the frame
  localparam int unsigned POS_SRC  = 6;
  localparam int unsigned POS_TYPE = 12;
  localparam int unsigned POS_CMD  = 14;
  localparam int unsigned POS_SEQ  = 16;
  localparam int unsigned HDR_LEN  = 18;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_START,
    EV_ACK,
    EV_STOP
  } frame_event_e;

  // octet idx of an address, 0 = most significant
  function automatic logic [OCTET_W-1:0] addr_octet(input logic [MAC_W-1:0] addr, input int idx);
    logic [MAC_W-1:0] shifted;
    shifted = addr << (OCTET_W * idx);
    return shifted[MAC_W-1 -: OCTET_W];
  endfunction

endpackage

// File: rtl/cfp_hdr_tracker.sv
module cfp_hdr_tracker
  import cfp_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MAC_W-1:0]   local_mac,
  input  logic               rx_valid,
  input  logic [OCTET_W-1:0] rx_byte,
  input  logic               rx_sof,
  input  logic               rx_eof,
  output logic               byte_take,
  output logic [IDX_W-1:0]   byte_pos,
  output logic               dst_match,
  output logic [MAC_W-1:0]   src_addr,
  output logic [15:0]        type_word,
  output logic [15:0]        cmd_word,
  output logic [OCTET_W-1:0] seq_high
);

  localparam logic [IDX_W-1:0] P_SRC  = IDX_W'(POS_SRC);
  localparam logic [IDX_W-1:0] P_TYPE = IDX_W'(POS_TYPE);
  localparam logic [IDX_W-1:0] P_CMD  = IDX_W'(POS_CMD);
  localparam logic [IDX_W-1:0] P_SEQ  = IDX_W'(POS_SEQ);
  localparam logic [IDX_W-1:0] P_CAP  = IDX_W'(HDR_LEN);

  logic             open_q;
  logic [IDX_W-1:0] next_q;

  // position counter saturates past the header so padding never wraps it
  function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] p);
    return (p >= P_CAP) ? P_CAP : p + 1'b1;
  endfunction

  assign byte_take = rx_valid && (rx_sof || open_q);
  assign byte_pos  = rx_sof ? '0 : next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      next_q    <= '0;
      dst_match <= 1'b0;
      src_addr  <= '0;
      type_word <= '0;
      cmd_word  <= '0;
      seq_high  <= '0;
    end else if (byte_take) begin
      open_q <= !rx_eof;
      next_q <= advance(byte_pos);
      if (byte_pos < P_SRC) begin
        dst_match <= ((byte_pos == '0) || dst_match) &&
                     (rx_byte == addr_octet(local_mac, int'(byte_pos)));
      end else if (byte_pos < P_TYPE) begin
        src_addr <= {src_addr[MAC_W-OCTET_W-1:0], rx_byte};
      end else if (byte_pos < P_CMD) begin
        type_word <= {type_word[7:0], rx_byte};
      end else if (byte_pos < P_SEQ) begin
        cmd_word <= {cmd_word[7:0], rx_byte};
      end else if (byte_pos == P_SEQ) begin
        seq_high <= rx_byte;
      end
    end
  end

endmodule

// File: rtl/cfp_cmd_decode.sv
module cfp_cmd_decode
  import cfp_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic               byte_take,
  input  logic [IDX_W-1:0]   byte_pos,
  input  logic [OCTET_W-1:0] rx_byte,
  input  logic               dst_match,
  input  logic [15:0]        type_word,
  input  logic [15:0]        cmd_word,
  input  logic [OCTET_W-1:0] seq_high,
  output frame_event_e       ev,
  output logic [SEQ_W-1:0]   seq_word
);

  localparam logic [IDX_W-1:0] P_CMD_LAST = IDX_W'(POS_CMD + 1);
  localparam logic [IDX_W-1:0] P_SEQ_LAST = IDX_W'(POS_SEQ + 1);

  logic        hdr_ok;
  logic [15:0] cmd_now;

  assign hdr_ok   = dst_match && (type_word == FRAME_TYPE);
  assign cmd_now  = {cmd_word[7:0], rx_byte};
  assign seq_word = {seq_high, rx_byte};

  always_comb begin
    ev = EV_NONE;
    if (byte_take && hdr_ok) begin
      if (byte_pos == P_CMD_LAST) begin
        if (cmd_now == CMD_WORD_START)     ev = EV_START;
        else if (cmd_now == CMD_WORD_STOP) ev = EV_STOP;
      end else if (byte_pos == P_SEQ_LAST && cmd_word == CMD_WORD_ACK) begin
        ev = EV_ACK;
      end
    end
  end

endmodule

// File: rtl/ctrl_frame_parser.sv
module ctrl_frame_parser
  import cfp_pkg::*;
#(
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned SET_W = SEQ_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       local_mac,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_sof,
  input  logic              rx_eof,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              ack_pulse,
  output logic [SET_W-1:0]  ack_set,
  output logic [SLOT_W-1:0] ack_slot,
  output logic [47:0]       peer_mac
);

  localparam int unsigned IDX_W = $clog2(HDR_LEN + 1);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [SEQ_W-1:0] s);
    return s[SLOT_W-1:0];
  endfunction

  function automatic logic [SET_W-1:0] set_of(input logic [SEQ_W-1:0] s);
    return s[SEQ_W-1:SLOT_W];
  endfunction

  logic               byte_take;
  logic [IDX_W-1:0]   byte_pos;
  logic               hdr_dst_ok;
  logic               hdr_type_ok;
  logic [MAC_W-1:0]   src_addr;
  logic [15:0]        type_word;
  logic [15:0]        cmd_word;
  logic [OCTET_W-1:0] seq_high;
  frame_event_e       ev_now;
  logic [SEQ_W-1:0]   seq_word;

  cfp_hdr_tracker #(.IDX_W(IDX_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .local_mac (local_mac),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .byte_take (byte_take),
    .byte_pos  (byte_pos),
    .dst_match (hdr_dst_ok),
    .src_addr  (src_addr),
    .type_word (type_word),
    .cmd_word  (cmd_word),
    .seq_high  (seq_high)
  );

  cfp_cmd_decode #(.IDX_W(IDX_W)) u_dec (
    .byte_take (byte_take),
    .byte_pos  (byte_pos),
    .rx_byte   (rx_byte),
    .dst_match (hdr_dst_ok),
    .type_word (type_word),
    .cmd_word  (cmd_word),
    .seq_high  (seq_high),
    .ev        (ev_now),
    .seq_word  (seq_word)
  );

  // observation wire for the checker
  assign hdr_type_ok = (type_word == FRAME_TYPE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      ack_pulse   <= 1'b0;
      ack_set     <= '0;
      ack_slot    <= '0;
      peer_mac    <= '0;
    end else begin
      start_pulse <= (ev_now == EV_START);
      stop_pulse  <= (ev_now == EV_STOP);
      ack_pulse   <= (ev_now == EV_ACK);
      if (ev_now == EV_ACK) begin
        ack_set  <= set_of(seq_word);
        ack_slot <= slot_of(seq_word);
      end
      if (ev_now == EV_START) begin
        peer_mac <= src_addr;
      end
    end
  end

endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int unsigned SET_W  = 11,
  parameter int unsigned SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              start_pulse,
  input logic              stop_pulse,
  input logic              ack_pulse,
  input logic [SET_W-1:0]  ack_set,
  input logic [SLOT_W-1:0] ack_slot,
  input logic [47:0]       peer_mac,
  input logic              dst_ok,
  input logic              type_ok
);

  logic any_pulse;
  assign any_pulse = start_pulse || stop_pulse || ack_pulse;

  a_r12_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, stop_pulse, ack_pulse}));

  a_r5_peer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |-> $stable(peer_mac));

  a_r4_ack_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_pulse |-> $stable({ack_set, ack_slot}));

  a_r6_needs_dst: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(dst_ok));

  a_r7_needs_type: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(type_ok));

  a_r11_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(rx_valid));

endmodule

bind ctrl_frame_parser cfp_checker #(.SET_W(SET_W), .SLOT_W(SLOT_W)) u_cfp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .ack_pulse   (ack_pulse),
  .ack_set     (ack_set),
  .ack_slot    (ack_slot),
  .peer_mac    (peer_mac),
  .dst_ok      (hdr_dst_ok),
  .type_ok     (hdr_type_ok)
);

// File: tb/ctrl_frame_parser_tb_top.sv
`timescale 1ns/1ps
module ctrl_frame_parser_tb_top;

  localparam int SLOT_W = 5;
  localparam int SET_W  = 16 - SLOT_W;
  localparam logic [47:0] LOCAL = 48'h02_1A_2B_3C_4D_5E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic start_pulse, stop_pulse, ack_pulse;
  logic [SET_W-1:0] ack_set;
  logic [SLOT_W-1:0] ack_slot;
  logic [47:0] peer_mac;

  always #2.5 clk = ~clk;

  ctrl_frame_parser #(.SLOT_W(SLOT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .local_mac(LOCAL),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .ack_pulse(ack_pulse),
    .ack_set(ack_set), .ack_slot(ack_slot), .peer_mac(peer_mac)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int n_start = 0, n_stop = 0, n_ack = 0, n_multi = 0;
  int t_start = -1, t_stop = -1, t_ack = -1;
  int dec15 = -1, dec17 = -1;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_pulse) begin n_start++; t_start = cyc; end
      if (stop_pulse)  begin n_stop++;  t_stop  = cyc; end
      if (ack_pulse)   begin n_ack++;   t_ack   = cyc; end
      if ((int'(start_pulse) + int'(stop_pulse) + int'(ack_pulse)) > 1) n_multi++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input logic [47:0] dst, input logic [47:0] src,
      input logic [15:0] et, input logic [15:0] op, input logic [15:0] sq, input int i);
    logic [47:0] t;
    if (i < 6)  begin t = dst << (8 * i);       return t[47:40]; end
    if (i < 12) begin t = src << (8 * (i - 6)); return t[47:40]; end
    case (i)
      12: return et[15:8];
      13: return et[7:0];
      14: return op[15:8];
      15: return op[7:0];
      16: return sq[15:8];
      17: return sq[7:0];
      default: begin
        // padding imitating a start header
        case (i % 4)
          0: return 8'hFA;
          1: return 8'hDE;
          2: return 8'h00;
          default: return 8'h01;
        endcase
      end
    endcase
  endfunction

  task automatic send_frame(input logic [47:0] dst, input logic [47:0] src, input logic [15:0] et,
      input logic [15:0] op, input logic [15:0] sq, input int len, input bit gaps, input bit with_sof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1;
      rx_byte  = frame_byte(dst, src, et, op, sq, i);
      rx_sof   = with_sof && (i == 0);
      rx_eof   = (i == len - 1);
      if (i == 15) dec15 = cyc;
      if (i == 17) dec17 = cyc;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  dst_sel;   // 0 local, 1 low byte flipped, 2 high byte flipped
    logic [15:0] etype;
    logic [15:0] op;
    logic [15:0] seq;
    logic [7:0]  len;
    logic        gaps;
    logic [2:0]  exp;       // {start, stop, ack}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'hFADE, 16'h0001, 16'h0000, 8'd64, 1'b0, 3'b100, 4'd2},  // R2 start, R10 padding
    '{2'd0, 16'hFADE, 16'h0005, 16'h0000, 8'd64, 1'b1, 3'b010, 4'd3},  // R3 stop with gaps (R11)
    '{2'd0, 16'hFADE, 16'h0003, 16'hABCD, 8'd64, 1'b0, 3'b001, 4'd4},  // R4 ack
    '{2'd0, 16'hFADE, 16'h0003, 16'hFFFF, 8'd18, 1'b0, 3'b001, 4'd4},  // R4 ack, minimum length
    '{2'd0, 16'hFADE, 16'h0003, 16'h0020, 8'd64, 1'b1, 3'b001, 4'd4},  // R4 set 1 slot 0
    '{2'd1, 16'hFADE, 16'h0001, 16'h0000, 8'd64, 1'b0, 3'b000, 4'd6},  // R6 low dst byte
    '{2'd2, 16'hFADE, 16'h0003, 16'h1234, 8'd64, 1'b0, 3'b000, 4'd6},  // R6 high dst byte
    '{2'd0, 16'hFADF, 16'h0001, 16'h0000, 8'd64, 1'b0, 3'b000, 4'd7},  // R7
    '{2'd0, 16'h0800, 16'h0005, 16'h0000, 8'd64, 1'b0, 3'b000, 4'd7},  // R7
    '{2'd0, 16'hFADE, 16'h0002, 16'h0000, 8'd64, 1'b0, 3'b000, 4'd8},  // R8
    '{2'd0, 16'hFADE, 16'h0103, 16'h0042, 8'd64, 1'b0, 3'b000, 4'd8},  // R8 high command byte
    '{2'd0, 16'hFADE, 16'h0001, 16'h0000, 8'd15, 1'b0, 3'b000, 4'd9},  // R9 ends at byte 14
    '{2'd0, 16'hFADE, 16'h0001, 16'h0000, 8'd16, 1'b0, 3'b100, 4'd9},  // R9 ends on byte 15
    '{2'd0, 16'hFADE, 16'h0003, 16'h0777, 8'd17, 1'b0, 3'b000, 4'd9},  // R9 ack ends at 16
    '{2'd0, 16'hFADE, 16'h0005, 16'h0000, 8'd16, 1'b1, 3'b010, 4'd9},  // R9 stop ends on 15
    '{2'd0, 16'hFADE, 16'h0003, 16'h0555, 8'd16, 1'b0, 3'b000, 4'd9}   // R9 ack ends at 15
  };

  function automatic logic [47:0] dst_of(input logic [1:0] sel);
    case (sel)
      2'd1:    return LOCAL ^ 48'h00_00_00_00_00_01;
      2'd2:    return LOCAL ^ 48'h80_00_00_00_00_00;
      default: return LOCAL;
    endcase
  endfunction

  logic [47:0] exp_peer = '0;
  logic [15:0] exp_seq  = '0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int s0, p0, a0;
    logic [47:0] src;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 pulses in reset", {start_pulse, stop_pulse, ack_pulse}, 3'b000);
    check("R1 peer_mac in reset", peer_mac, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack fields after reset", {ack_set, ack_slot}, 16'h0);
    check("R1 pulses after reset", {start_pulse, stop_pulse, ack_pulse}, 3'b000);

    for (int v = 0; v < NV; v++) begin
      s0 = n_start; p0 = n_stop; a0 = n_ack;
      src = 48'h0A_00_00_00_10_00 + 48'(v);
      send_frame(dst_of(VEC[v].dst_sel), src, VEC[v].etype, VEC[v].op, VEC[v].seq,
                 int'(VEC[v].len), VEC[v].gaps, 1'b1);
      check($sformatf("R%0d vec%0d start count", VEC[v].req, v), 64'(n_start - s0), 64'(VEC[v].exp[2]));
      check($sformatf("R%0d vec%0d stop count", VEC[v].req, v),  64'(n_stop - p0),  64'(VEC[v].exp[1]));
      check($sformatf("R%0d vec%0d ack count", VEC[v].req, v),   64'(n_ack - a0),   64'(VEC[v].exp[0]));
      if (VEC[v].exp[2]) begin
        exp_peer = src;
        check($sformatf("R2 vec%0d start cycle", v), 64'(t_start), 64'(dec15 + 1));
      end
      if (VEC[v].exp[1])
        check($sformatf("R3 vec%0d stop cycle", v), 64'(t_stop), 64'(dec15 + 1));
      if (VEC[v].exp[0]) begin
        exp_seq = VEC[v].seq;
        check($sformatf("R4 vec%0d ack cycle", v), 64'(t_ack), 64'(dec17 + 1));
      end
      check($sformatf("R4 vec%0d ack_slot", v), ack_slot, exp_seq % 32);
      check($sformatf("R4 vec%0d ack_set", v), ack_set, exp_seq / 32);
      check($sformatf("R5 vec%0d peer_mac", v), peer_mac, exp_peer);
    end

    // R11: header bytes with no open frame and no rx_sof are ignored
    s0 = n_start;
    send_frame(LOCAL, 48'h0B_0B_0B_0B_0B_0B, 16'hFADE, 16'h0001, 16'h0, 18, 1'b0, 1'b0);
    check("R11 bytes outside frame start count", 64'(n_start - s0), 64'd0);
    check("R11 bytes outside frame peer_mac", peer_mac, exp_peer);

    // R11: rx_sof in mid-frame restarts at position 0
    s0 = n_start; p0 = n_stop;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0;
      rx_byte = frame_byte(LOCAL, 48'h0C_0C_0C_0C_0C_0C, 16'hFADE, 16'h0005, 16'h0, i);
    end
    send_frame(LOCAL, 48'h0D_0E_0F_10_11_12, 16'hFADE, 16'h0001, 16'h0, 64, 1'b0, 1'b1);
    exp_peer = 48'h0D_0E_0F_10_11_12;
    check("R11 restart start count", 64'(n_start - s0), 64'd1);
    check("R11 restart stop count", 64'(n_stop - p0), 64'd0);
    check("R5 restart peer_mac", peer_mac, exp_peer);

    // R12 across everything sent
    check("R12 simultaneous pulses", 64'(n_multi), 64'd0);

    // R1 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 second reset peer_mac", peer_mac, 48'h0);
    check("R1 second reset ack fields", {ack_set, ack_slot}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after second reset pulses", {start_pulse, stop_pulse, ack_pulse}, 3'b000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule